// File: doc/BRIEF.md
# Pulse-Aligned Trigger Timestamp Clock

This block keeps a time-of-day count for an acquisition system. The count has two parts: a whole-seconds value and a sub-second tick count that advances once per clock and wraps once per second. The clock is meant to be derived from a frequency reference, so the tick count is a fixed number of ticks per second, set by a parameter.

An optional once-per-second pulse input can discipline the count. On each rising edge of that pulse, the tick count is forced to zero. The seconds value snaps to whichever whole second is closer. Software may also preset the seconds value. The new value waits and is applied at the next second boundary, so a second is never split.

On every trigger strobe, the block captures the seconds and tick values into a timestamp output. A valid strobe accompanies the captured values.

Top module: `pps_ts_clock`

## Requirements
- R1: After reset, ts_valid, ts_sec, ts_frac and pps_seen are all 0. The internal seconds and tick counts start at 0 on the third clock edge after rst_n rises, because two edges are spent in the reset synchronizer.
- R2: The tick count advances by one on every clock edge through 0 .. TICKS_PER_SEC-1. On the edge where it sits at TICKS_PER_SEC-1, it wraps to 0 and the seconds value increments by one.
- R3: When trig_in is high at a clock edge, ts_valid is high for exactly the following cycle. At the same time, ts_sec and ts_frac show the seconds and tick values current at that edge. Both hold their value until the next trigger.
- R4: pps_in passes through a two-stage synchronizer followed by a rising-edge detector. If pps_in is first sampled high at edge k, the correction is applied at edge k+2. Keeping pps_in high after that causes no further correction.
- R5: A correction sets the tick count to 0. If the tick count at that edge is at least TICKS_PER_SEC/2, the seconds value increments by one; otherwise it is left unchanged.
- R6: While pps_en is low, pps_in has no effect and the clock free-runs.
- R7: A sec_load_valid pulse stores sec_load_value as pending. At the next wrap or correction, the pending value becomes the seconds value, and no rounding is applied. Before that point, the seconds value is not affected. A newer load made before the value is applied replaces the older one.
- R8: If a trigger and a correction fall on the same edge, the timestamp shows the corrected value: the rounded (or loaded) seconds and a tick count of 0.
- R9: pps_seen goes high after the first correction and stays high. It is cleared one edge after pps_en goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, a multiple of the reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_in | input | 1 | Once-per-second alignment pulse, asynchronous |
| pps_en | input | 1 | Enables pulse alignment |
| sec_load_valid | input | 1 | Strobe: store a new seconds value |
| sec_load_value | input | SEC_W | Seconds value to apply at the next boundary |
| trig_in | input | 1 | Trigger strobe |
| ts_valid | output | 1 | Timestamp strobe, one cycle |
| ts_sec | output | SEC_W | Captured seconds |
| ts_frac | output | FRAC_W | Captured tick count |
| pps_seen | output | 1 | Sticky: a correction has occurred since the enable |

## Verification
The bench first lets the clock free-run and reads it with pairs of triggers that straddle a wrap, which checks the plain counting and carry path. It then applies corrections with the tick count at half-minus-one and at exactly half. These two cases separate a correct round-up threshold from an off-by-one threshold, and one of them coincides with a trigger to test which value gets captured. Two further stimulus patterns test the pending path: a correction with a pending load, and a double load before a wrap. These distinguish "applied at the boundary" from "applied immediately" and from "first value wins". Pulses sent with the enable low, and a pulse held high for many cycles, confirm that nothing besides an enabled rising edge moves the count.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  typedef enum logic [1:0] {
    STEP_COUNT = 2'd0,
    STEP_WRAP  = 2'd1,
    STEP_ALIGN = 2'd2
  } step_e;
endpackage

// File: rtl/tsc_rst_sync.sv
module tsc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/tsc_pps_detect.sv
module tsc_pps_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pin,
  output logic rise,
  output logic seen
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;
  logic                   seen_d, seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise = en & sync_q[SYNC_STAGES-1] & ~last_q;

  always_comb begin
    seen_d = seen_q;
    if (!en)       seen_d = 1'b0;
    else if (rise) seen_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= seen_d;
  end

  assign seen = seen_q;

  p_one_shot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
  p_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !rise);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && en) |=> seen);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !seen);
endmodule

// File: rtl/tsc_tod_counter.sv
module tsc_tod_counter
  import tsc_pkg::*;
#(
  parameter int TICKS_PER_SEC = 250_000_000,
  parameter int SEC_W         = 32,
  parameter int FRAC_W        = $clog2(TICKS_PER_SEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              align,
  input  logic              load_valid,
  input  logic [SEC_W-1:0]  load_sec,
  output logic [SEC_W-1:0]  sec_cur,
  output logic [FRAC_W-1:0] frac_cur,
  output logic [SEC_W-1:0]  sec_nxt,
  output logic [FRAC_W-1:0] frac_nxt
);
  localparam logic [FRAC_W-1:0] LAST = FRAC_W'(TICKS_PER_SEC - 1);
  localparam logic [FRAC_W-1:0] HALF = FRAC_W'(TICKS_PER_SEC / 2);

  step_e             step;
  logic [SEC_W-1:0]  sec_q, sec_d;
  logic [FRAC_W-1:0] frac_q, frac_d;
  logic              pend_q, pend_d;
  logic [SEC_W-1:0]  pval_q;

  always_comb begin
    if (align)               step = STEP_ALIGN;
    else if (frac_q == LAST) step = STEP_WRAP;
    else                     step = STEP_COUNT;
  end

  always_comb begin
    sec_d  = sec_q;
    frac_d = frac_q + 1'b1;
    pend_d = pend_q;
    case (step)
      STEP_ALIGN: begin
        frac_d = '0;
        pend_d = 1'b0;
        if (pend_q)               sec_d = pval_q;
        else if (frac_q >= HALF)  sec_d = sec_q + 1'b1;
      end
      STEP_WRAP: begin
        frac_d = '0;
        pend_d = 1'b0;
        sec_d  = pend_q ? pval_q : sec_q + 1'b1;
      end
      default: ;
    endcase
    if (load_valid) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      frac_q <= '0;
      pend_q <= 1'b0;
    end else begin
      sec_q  <= sec_d;
      frac_q <= frac_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pval_q <= '0;
    else if (load_valid) pval_q <= load_sec;
  end

  assign sec_cur  = sec_q;
  assign frac_cur = frac_q;
  assign sec_nxt  = sec_d;
  assign frac_nxt = frac_d;

  p_frac_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frac_q <= LAST);
  p_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_q != LAST && !align) |=> (frac_q == $past(frac_q) + 1'b1) && $stable(sec_q));
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frac_q == LAST && !align && !pend_q) |=> (frac_q == '0) && (sec_q == $past(sec_q) + 1'b1));
  p_align_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    align |=> frac_q == '0);
  p_round_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (align && !pend_q && frac_q >= HALF) |=> sec_q == $past(sec_q) + 1'b1);
  p_round_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (align && !pend_q && frac_q < HALF) |=> $stable(sec_q));
  p_load_apply_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((align || frac_q == LAST) && pend_q) |=> sec_q == $past(pval_q));
endmodule

// File: rtl/tsc_trig_latch.sv
module tsc_trig_latch #(
  parameter int SEC_W  = 32,
  parameter int FRAC_W = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              align,
  input  logic [SEC_W-1:0]  sec_cur,
  input  logic [FRAC_W-1:0] frac_cur,
  input  logic [SEC_W-1:0]  sec_nxt,
  input  logic [FRAC_W-1:0] frac_nxt,
  output logic              ts_valid,
  output logic [SEC_W-1:0]  ts_sec,
  output logic [FRAC_W-1:0] ts_frac
);
  logic [SEC_W-1:0]  sec_sel;
  logic [FRAC_W-1:0] frac_sel;
  logic              vld_q;
  logic [SEC_W-1:0]  sec_q;
  logic [FRAC_W-1:0] frac_q;

  always_comb begin
    sec_sel  = align ? sec_nxt  : sec_cur;
    frac_sel = align ? frac_nxt : frac_cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= trig;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= '0;
      frac_q <= '0;
    end else if (trig) begin
      sec_q  <= sec_sel;
      frac_q <= frac_sel;
    end
  end

  assign ts_valid = vld_q;
  assign ts_sec   = sec_q;
  assign ts_frac  = frac_q;

  p_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> ts_valid);
  p_strobe_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> !ts_valid);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !trig |=> $stable(ts_sec) && $stable(ts_frac));
  p_corrected_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && align) |=> ts_frac == '0);
endmodule

// File: rtl/pps_ts_clock.sv
module pps_ts_clock #(
  parameter int TICKS_PER_SEC = 250_000_000,
  parameter int SEC_W         = 32,
  parameter int SYNC_STAGES   = 2,
  parameter int FRAC_W        = $clog2(TICKS_PER_SEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pps_in,
  input  logic              pps_en,
  input  logic              sec_load_valid,
  input  logic [SEC_W-1:0]  sec_load_value,
  input  logic              trig_in,
  output logic              ts_valid,
  output logic [SEC_W-1:0]  ts_sec,
  output logic [FRAC_W-1:0] ts_frac,
  output logic              pps_seen
);
  logic              rst_n_int;
  logic              align;
  logic [SEC_W-1:0]  sec_cur, sec_nxt;
  logic [FRAC_W-1:0] frac_cur, frac_nxt;

  tsc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  tsc_pps_detect #(.SYNC_STAGES(SYNC_STAGES)) u_pps (
    .clk   (clk),
    .rst_n (rst_n_int),
    .en    (pps_en),
    .pin   (pps_in),
    .rise  (align),
    .seen  (pps_seen)
  );

  tsc_tod_counter #(
    .TICKS_PER_SEC (TICKS_PER_SEC),
    .SEC_W         (SEC_W),
    .FRAC_W        (FRAC_W)
  ) u_tod (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .align      (align),
    .load_valid (sec_load_valid),
    .load_sec   (sec_load_value),
    .sec_cur    (sec_cur),
    .frac_cur   (frac_cur),
    .sec_nxt    (sec_nxt),
    .frac_nxt   (frac_nxt)
  );

  tsc_trig_latch #(.SEC_W(SEC_W), .FRAC_W(FRAC_W)) u_lat (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .trig     (trig_in),
    .align    (align),
    .sec_cur  (sec_cur),
    .frac_cur (frac_cur),
    .sec_nxt  (sec_nxt),
    .frac_nxt (frac_nxt),
    .ts_valid (ts_valid),
    .ts_sec   (ts_sec),
    .ts_frac  (ts_frac)
  );
endmodule

// File: tb/pps_ts_clock_tb.sv
module pps_ts_clock_tb;
  localparam int TPS    = 20;
  localparam int SEC_W  = 32;
  localparam int FRAC_W = $clog2(TPS);

  logic              clk = 1'b0;
  logic              rst_n;
  logic              pps_in, pps_en, sec_load_valid, trig_in;
  logic [SEC_W-1:0]  sec_load_value;
  logic              ts_valid, pps_seen;
  logic [SEC_W-1:0]  ts_sec;
  logic [FRAC_W-1:0] ts_frac;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int bs, bf, be;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pps_ts_clock #(.TICKS_PER_SEC(TPS), .SEC_W(SEC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pps_in(pps_in), .pps_en(pps_en),
    .sec_load_valid(sec_load_valid), .sec_load_value(sec_load_value),
    .trig_in(trig_in), .ts_valid(ts_valid), .ts_sec(ts_sec),
    .ts_frac(ts_frac), .pps_seen(pps_seen)
  );

  function automatic int exp_s(int e);
    return bs + (bf + e - be) / TPS;
  endfunction
  function automatic int exp_f(int e);
    return (bf + e - be) % TPS;
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // trigger captured at edge e; compare with expected seconds/ticks
  task automatic trig_check(string req, int es, int ef, bit use_model);
    int e;
    @(negedge clk) trig_in = 1'b1;
    @(negedge clk) trig_in = 1'b0;
    e = cyc;
    if (use_model) begin es = exp_s(e); ef = exp_f(e); end
    check(ts_valid == 1'b1, {req, " strobe"}, int'(ts_valid), 1);
    check(ts_sec == SEC_W'(es), {req, " sec"}, int'(ts_sec), es);
    check(ts_frac == FRAC_W'(ef), {req, " frac"}, int'(ts_frac), ef);
  endtask

  task automatic t_reset;
    int rel;
    rst_n = 1'b0; pps_in = 0; pps_en = 0; sec_load_valid = 0;
    sec_load_value = '0; trig_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rel = cyc;
    @(negedge clk);
    check(ts_valid == 0, "R1 ts_valid", int'(ts_valid), 0);
    check(ts_sec == 0, "R1 ts_sec", int'(ts_sec), 0);
    check(ts_frac == 0, "R1 ts_frac", int'(ts_frac), 0);
    check(pps_seen == 0, "R1 pps_seen", int'(pps_seen), 0);
    bs = 0; bf = 0; be = rel + 3;
    trig_check("R1 start", 0, 0, 1);
  endtask

  task automatic t_free_run;
    trig_check("R2 count", 0, 0, 1);
    repeat (23) @(negedge clk);
    trig_check("R2 wrap", 0, 0, 1);
    @(negedge clk);
    check(ts_valid == 0, "R3 strobe one cycle", int'(ts_valid), 0);
    repeat (3) @(negedge clk);
    check(ts_sec == SEC_W'(exp_s(cyc - 4)), "R3 hold", int'(ts_sec), exp_s(cyc - 4));
  endtask

  task automatic t_load;
    int b, c;
    while (exp_f(cyc + 1) != 3) @(negedge clk);
    b = cyc + 17;
    sec_load_valid = 1'b1; sec_load_value = 77;
    @(negedge clk) sec_load_value = 100;
    @(negedge clk) sec_load_valid = 1'b0;
    trig_check("R7 not mid-second", 0, 0, 1);
    repeat (20) @(negedge clk);
    @(negedge clk) trig_in = 1'b1;
    @(negedge clk) trig_in = 1'b0;
    c = cyc;
    check(ts_sec == SEC_W'(100 + (c - b - 1) / TPS), "R7 applied at wrap, newest wins",
          int'(ts_sec), 100 + (c - b - 1) / TPS);
    check(ts_frac == FRAC_W'((c - b - 1) % TPS), "R7 frac after wrap",
          int'(ts_frac), (c - b - 1) % TPS);
    bs = 100; bf = 0; be = b + 1;
  endtask

  task automatic t_pps_off;
    pps_en = 1'b0;
    pps_in = 1'b1;
    repeat (5) @(negedge clk);
    pps_in = 1'b0;
    repeat (3) @(negedge clk);
    trig_check("R6 ignored", 0, 0, 1);
    check(pps_seen == 0, "R6 no status", int'(pps_seen), 0);
  endtask

  task automatic t_pps(int pre, bit with_load, bit same_trig, string req);
    int a, snew;
    pps_en = 1'b1;
    @(negedge clk);
    while (exp_f(cyc + 3) != pre) @(negedge clk);
    a = cyc + 3;
    snew = with_load ? 500 : exp_s(a) + ((pre >= TPS / 2) ? 1 : 0);
    pps_in = 1'b1;
    if (with_load) begin sec_load_valid = 1'b1; sec_load_value = 500; end
    @(negedge clk) sec_load_valid = 1'b0;
    @(negedge clk) if (same_trig) trig_in = 1'b1;
    @(negedge clk) trig_in = 1'b0;
    if (same_trig) begin
      check(ts_valid == 1, "R8 strobe", int'(ts_valid), 1);
      check(ts_sec == SEC_W'(snew), "R8 corrected sec", int'(ts_sec), snew);
      check(ts_frac == 0, "R8 corrected frac", int'(ts_frac), 0);
    end
    check(pps_seen == 1, "R9 set", int'(pps_seen), 1);
    bs = snew; bf = 0; be = a + 1;
    repeat (6) @(negedge clk);
    trig_check(req, 0, 0, 1);         // pin still high: R4 single action
    pps_in = 1'b0;
  endtask

  task automatic t_clear;
    @(negedge clk) pps_en = 1'b0;
    @(negedge clk);
    check(pps_seen == 0, "R9 cleared", int'(pps_seen), 0);
  endtask

  initial begin
    t_reset();
    t_free_run();
    t_load();
    t_pps_off();
    t_pps(9, 0, 0, "R5 keep below half, R4");
    t_pps(10, 0, 1, "R5 round up at half, R4");
    t_pps(14, 1, 0, "R7 load at pulse");
    t_clear();
    repeat (30) @(negedge clk);
    trig_check("R2 free run after", 0, 0, 1);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule